// File: doc/BRIEF.md
# H-Bridge Current-Chopping PWM Controller

This block produces the four gate enables of a single H-bridge: a high-side and a low-side switch on each of the two legs. Two direction inputs set the commanded bridge state. When they disagree, the bridge drives the load in the selected direction and a fixed-period current-chopping loop runs on top of that command. Every period opens with a drive phase. During a blanking window at the start of that phase, an already synchronised current-trip bit is ignored. A trip seen after the window ends the drive phase. The bridge then holds one of three decay schemes until the period boundary.

Slow decay turns on both low sides so the winding current recirculates. Fast decay reverses the bridge until a zero-current detect bit asserts, and then turns every switch off. Mixed decay behaves as fast decay up to three quarters of the period and as slow decay after that. When both direction inputs are equal, the legs follow them directly and no chopping takes place. Every change-over inside a leg passes through a break-before-make gap of configurable length.

The period, blanking and dead-time lengths are parameters counted in clock cycles. With a 50 MHz clock the defaults give a 20 µs period, a 3.76 µs blanking window and a switch point at cycle 750. Every pin is plain control or status, and no pin carries a data stream, so the block has no valid/ready handshake and no back-pressure.

Top module: `hbridge_chopper`

## Requirements
- R1: While reset is asserted, all four gate enables are low. The period counter holds cycle 0 in the first cycle after reset is released and then counts 0 to PERIOD_CYC-1, wrapping around.
- R2: When dir_a equals dir_b, the legs follow them directly. The value 1,1 turns on both high sides, giving {hs_a,ls_a,hs_b,ls_b}=1010. The value 0,0 turns on both low sides, giving 0101. In this state, trip_i, zero_i and decay_sel have no effect on the outputs.
- R3: When dir_a=1 and dir_b=0, the drive phase enables hs_a and ls_b (1001). When dir_a=0 and dir_b=1, it enables hs_b and ls_a (0110). Each period starts in the drive phase. If no trip is accepted, drive continues to the period boundary.
- R4: trip_i is ignored while the period counter is below BLANK_CYC. This window is the minimum on-time of every drive phase.
- R5: With decay_sel=2'b00 (slow), an accepted trip ends the drive phase and both low sides stay on (0101) until the period ends.
- R6: With decay_sel=2'b10 (fast), an accepted trip reverses the bridge relative to the drive phase. Once zero_i is seen, all four switches go off (0000) and stay off until the period ends.
- R7: decay_sel=2'b01 (mixed) and the spare code 2'b11 both apply fast decay until the counter reaches 3*PERIOD_CYC/4, and slow decay from there to the end of the period. A trip accepted at or after that point goes straight to slow decay.
- R8: The high-side and low-side switches of one leg are never on in the same cycle.
- R9: A switch turns on only after both switches of its leg have been off for at least DEAD_CYC consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_a | input | 1 | Commanded state of leg A |
| dir_b | input | 1 | Commanded state of leg B |
| trip_i | input | 1 | Synchronised current-trip comparator output |
| zero_i | input | 1 | Synchronised zero-current detect |
| decay_sel | input | 2 | Decay scheme: 00 slow, 01 mixed, 10 fast, 11 treated as mixed |
| hs_a | output | 1 | Leg A high-side enable |
| ls_a | output | 1 | Leg A low-side enable |
| hs_b | output | 1 | Leg B high-side enable |
| ls_b | output | 1 | Leg B low-side enable |

## Verification
The bench builds the block with PERIOD_CYC=200, BLANK_CYC=40 and DEAD_CYC=2, which places the mixed switch point at cycle 150. With these short windows, every decay scheme can be seen across whole periods and back-to-back periods. That covers a trip held through blanking, a trip landing after the mixed switch point, and the return to drive at each boundary, all within a few thousand cycles. Because a dead time of two is longer than the one-cycle minimum, a counter that ignores the gap setting would be caught.

// File: rtl/hb_pkg.sv
package hb_pkg;
  typedef enum logic [1:0] {
    DEC_SLOW  = 2'b00,
    DEC_MIXED = 2'b01,
    DEC_FAST  = 2'b10,
    DEC_SPARE = 2'b11
  } decay_e;

  typedef enum logic [1:0] {
    PH_DRIVE = 2'd0,
    PH_FAST  = 2'd1,
    PH_SLOW  = 2'd2,
    PH_FLOAT = 2'd3
  } phase_e;

  typedef enum logic [1:0] {
    LEG_FLOAT = 2'd0,
    LEG_HIGH  = 2'd1,
    LEG_LOW   = 2'd2
  } leg_e;
endpackage

// File: rtl/hb_period_timer.sv
module hb_period_timer #(
  parameter int PERIOD_CYC = 1000,
  parameter int CW         = $clog2(PERIOD_CYC)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [CW-1:0] cnt_o,
  output logic          wrap_o
);
  localparam logic [CW-1:0] LAST = CW'(PERIOD_CYC - 1);

  assign wrap_o = (cnt_o == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_o <= '0;
    else if (wrap_o) cnt_o <= '0;
    else             cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/hb_chop_fsm.sv
module hb_chop_fsm
  import hb_pkg::*;
#(
  parameter int CW        = 10,
  parameter int BLANK_CYC = 188,
  parameter int MIX_CYC   = 750
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cnt_i,
  input  logic          wrap_i,
  input  logic          trip_i,
  input  logic          zero_i,
  input  logic [1:0]    decay_sel,
  output phase_e        phase_o
);
  localparam logic [CW-1:0] BLANK_L = CW'(BLANK_CYC);
  localparam logic [CW-1:0] MIXPRE  = CW'(MIX_CYC - 1);

  phase_e phase_n;
  logic   mixed_q, mixed_n;
  logic   past_mix;

  // The state change lands on the cycle where the counter equals MIX_CYC.
  assign past_mix = (cnt_i >= MIXPRE);

  always_comb begin
    phase_n = phase_o;
    mixed_n = mixed_q;
    if (wrap_i) begin
      phase_n = PH_DRIVE;
      mixed_n = 1'b0;
    end else begin
      unique case (phase_o)
        PH_DRIVE: if (trip_i && (cnt_i >= BLANK_L)) begin
          unique case (decay_e'(decay_sel))
            DEC_SLOW: phase_n = PH_SLOW;
            DEC_FAST: begin phase_n = PH_FAST; mixed_n = 1'b0; end
            default: begin
              mixed_n = 1'b1;
              phase_n = past_mix ? PH_SLOW : PH_FAST;
            end
          endcase
        end
        PH_FAST: begin
          if (mixed_q && past_mix) phase_n = PH_SLOW;
          else if (zero_i)         phase_n = PH_FLOAT;
        end
        PH_FLOAT: if (mixed_q && past_mix) phase_n = PH_SLOW;
        default: phase_n = phase_o;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_o <= PH_DRIVE;
      mixed_q <= 1'b0;
    end else begin
      phase_o <= phase_n;
      mixed_q <= mixed_n;
    end
  end
endmodule

// File: rtl/hb_leg_deadtime.sv
module hb_leg_deadtime
  import hb_pkg::*;
#(
  parameter int DEAD_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  leg_e demand_i,
  output logic hs_o,
  output logic ls_o
);
  localparam int OW = (DEAD_CYC < 1) ? 1 : $clog2(DEAD_CYC + 1);
  localparam logic [OW-1:0] DEAD_L = OW'(DEAD_CYC);

  logic [OW-1:0] off_cnt;
  logic          gap_done;

  assign gap_done = (off_cnt >= DEAD_L);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_o    <= 1'b0;
      ls_o    <= 1'b0;
      off_cnt <= '0;
    end else begin
      if (hs_o || ls_o)          off_cnt <= '0;
      else if (off_cnt < DEAD_L) off_cnt <= off_cnt + 1'b1;

      unique case (demand_i)
        LEG_HIGH: begin
          if (ls_o)                      ls_o <= 1'b0;
          else if (!hs_o && gap_done)    hs_o <= 1'b1;
        end
        LEG_LOW: begin
          if (hs_o)                      hs_o <= 1'b0;
          else if (!ls_o && gap_done)    ls_o <= 1'b1;
        end
        default: begin
          hs_o <= 1'b0;
          ls_o <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/hbridge_chopper.sv
module hbridge_chopper
  import hb_pkg::*;
#(
  parameter int PERIOD_CYC = 1000,
  parameter int BLANK_CYC  = 188,
  parameter int DEAD_CYC   = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dir_a,
  input  logic       dir_b,
  input  logic       trip_i,
  input  logic       zero_i,
  input  logic [1:0] decay_sel,
  output logic       hs_a,
  output logic       ls_a,
  output logic       hs_b,
  output logic       ls_b
);
  localparam int CW      = $clog2(PERIOD_CYC);
  localparam int MIX_CYC = (PERIOD_CYC * 3) / 4;
  localparam int NLEG    = 2;

  logic [CW-1:0] cnt;
  logic          wrap;
  phase_e        phase;
  leg_e          demand [NLEG];
  logic [NLEG-1:0] hs_q, ls_q;

  hb_period_timer #(.PERIOD_CYC(PERIOD_CYC), .CW(CW)) timer_i (
    .clk(clk), .rst_n(rst_n), .cnt_o(cnt), .wrap_o(wrap)
  );

  hb_chop_fsm #(.CW(CW), .BLANK_CYC(BLANK_CYC), .MIX_CYC(MIX_CYC)) fsm_i (
    .clk(clk), .rst_n(rst_n), .cnt_i(cnt), .wrap_i(wrap),
    .trip_i(trip_i), .zero_i(zero_i), .decay_sel(decay_sel), .phase_o(phase)
  );

  // Map the phase and direction onto the level wanted on each leg.
  always_comb begin
    leg_e drv_a, drv_b;
    drv_a = dir_a ? LEG_HIGH : LEG_LOW;
    drv_b = dir_b ? LEG_HIGH : LEG_LOW;
    demand[0] = drv_a;
    demand[1] = drv_b;
    if (dir_a != dir_b) begin
      unique case (phase)
        PH_DRIVE: begin demand[0] = drv_a;     demand[1] = drv_b;     end
        PH_FAST:  begin demand[0] = drv_b;     demand[1] = drv_a;     end
        PH_SLOW:  begin demand[0] = LEG_LOW;   demand[1] = LEG_LOW;   end
        default:  begin demand[0] = LEG_FLOAT; demand[1] = LEG_FLOAT; end
      endcase
    end
  end

  for (genvar g = 0; g < NLEG; g++) begin : g_leg
    hb_leg_deadtime #(.DEAD_CYC(DEAD_CYC)) leg_i (
      .clk(clk), .rst_n(rst_n), .demand_i(demand[g]),
      .hs_o(hs_q[g]), .ls_o(ls_q[g])
    );
  end

  assign hs_a = hs_q[0];
  assign ls_a = ls_q[0];
  assign hs_b = hs_q[1];
  assign ls_b = ls_q[1];
endmodule

// File: rtl/hbridge_chopper_chk.sv
module hbridge_chopper_chk #(
  parameter int DEAD_CYC = 2
) (
  input logic clk,
  input logic rst_n,
  input logic hs_a,
  input logic ls_a,
  input logic hs_b,
  input logic ls_b
);
  localparam int RW = $clog2(DEAD_CYC + 2);
  localparam logic [RW-1:0] DEAD_L = RW'(DEAD_CYC);

  logic [RW-1:0] run_a, run_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_a <= '0;
      run_b <= '0;
    end else begin
      if (hs_a || ls_a)         run_a <= '0;
      else if (run_a < DEAD_L)  run_a <= run_a + 1'b1;
      if (hs_b || ls_b)         run_b <= '0;
      else if (run_b < DEAD_L)  run_b <= run_b + 1'b1;
    end
  end

  a_r8_no_shoot_a: assert property (@(posedge clk) disable iff (!rst_n) !(hs_a && ls_a));
  a_r8_no_shoot_b: assert property (@(posedge clk) disable iff (!rst_n) !(hs_b && ls_b));
  a_r9_gap_hs_a: assert property (@(posedge clk) disable iff (!rst_n) $rose(hs_a) |-> (run_a >= DEAD_L));
  a_r9_gap_ls_a: assert property (@(posedge clk) disable iff (!rst_n) $rose(ls_a) |-> (run_a >= DEAD_L));
  a_r9_gap_hs_b: assert property (@(posedge clk) disable iff (!rst_n) $rose(hs_b) |-> (run_b >= DEAD_L));
  a_r9_gap_ls_b: assert property (@(posedge clk) disable iff (!rst_n) $rose(ls_b) |-> (run_b >= DEAD_L));
endmodule

bind hbridge_chopper hbridge_chopper_chk #(.DEAD_CYC(DEAD_CYC)) chk_i (
  .clk(clk), .rst_n(rst_n), .hs_a(hs_a), .ls_a(ls_a), .hs_b(hs_b), .ls_b(ls_b)
);

// File: tb/hbridge_chopper_tb_top.sv
`timescale 1ns/1ps
module hbridge_chopper_tb_top;
  localparam int P     = 200;
  localparam int BLANK = 40;
  localparam int DEAD  = 2;

  localparam logic [3:0] V_FWD  = 4'b1001;
  localparam logic [3:0] V_REV  = 4'b0110;
  localparam logic [3:0] V_LOWS = 4'b0101;
  localparam logic [3:0] V_HIGH = 4'b1010;
  localparam logic [3:0] V_OFF  = 4'b0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dir_a = 1'b0, dir_b = 1'b0, trip_i = 1'b0, zero_i = 1'b0;
  logic [1:0] decay_sel = 2'b00;
  logic hs_a, ls_a, hs_b, ls_b;

  int checks = 0;
  int errors = 0;
  int tcnt = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  hbridge_chopper #(.PERIOD_CYC(P), .BLANK_CYC(BLANK), .DEAD_CYC(DEAD)) dut_i (
    .clk(clk), .rst_n(rst_n), .dir_a(dir_a), .dir_b(dir_b), .trip_i(trip_i),
    .zero_i(zero_i), .decay_sel(decay_sel),
    .hs_a(hs_a), .ls_a(ls_a), .hs_b(hs_b), .ls_b(ls_b)
  );

  // Expected period position, from R1.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) tcnt <= 0;
    else        tcnt <= (tcnt == P - 1) ? 0 : tcnt + 1;
  end

  // Continuous monitors for R8 and R9.
  int run_a = 0, run_b = 0, gap_viol = 0, shoot_viol = 0, turn_ons = 0;
  logic pa = 1'b0, pb = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if ((hs_a && ls_a) || (hs_b && ls_b)) begin
        shoot_viol++;
        $display("FAIL R8: leg shoot-through, actual %b%b%b%b expected no leg with both on",
                 hs_a, ls_a, hs_b, ls_b);
      end
      if ((hs_a || ls_a) && !pa) begin
        turn_ons++;
        if (run_a < DEAD) begin
          gap_viol++;
          $display("FAIL R9: leg A gap actual %0d expected >= %0d", run_a, DEAD);
        end
      end
      if ((hs_b || ls_b) && !pb) begin
        turn_ons++;
        if (run_b < DEAD) begin
          gap_viol++;
          $display("FAIL R9: leg B gap actual %0d expected >= %0d", run_b, DEAD);
        end
      end
      run_a = (hs_a || ls_a) ? 0 : run_a + 1;
      run_b = (hs_b || ls_b) ? 0 : run_b + 1;
      pa = hs_a || ls_a;
      pb = hs_b || ls_b;
    end
  end

  task automatic check_out(input string req, input logic [3:0] exp);
    logic [3:0] act;
    act = {hs_a, ls_a, hs_b, ls_b};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: at cycle %0d actual %b expected %b", req, tcnt, act, exp);
    end
  endtask

  task automatic wait_cnt(input int k);
    do @(negedge clk); while (tcnt != k);
  endtask

  task automatic setup(input logic a, input logic b, input logic [1:0] sel);
    @(negedge clk);
    dir_a = a; dir_b = b; decay_sel = sel; trip_i = 1'b0; zero_i = 1'b0;
    wait_cnt(0);
  endtask

  task automatic pulse_trip(input int at);
    wait_cnt(at); trip_i = 1'b1;
    wait_cnt(at + 2); trip_i = 1'b0;
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    check_out("R1 reset", V_OFF);
    rst_n = 1'b1;
    checks++;
    if (tcnt != 0) begin
      errors++;
      $display("FAIL R1: counter after release actual %0d expected 0", tcnt);
    end
  endtask

  task automatic t_equal_inputs;
    setup(1'b1, 1'b1, 2'b10);
    wait_cnt(50); trip_i = 1'b1; zero_i = 1'b1;
    wait_cnt(60); check_out("R2 both high with trip", V_HIGH);
    wait_cnt(170); check_out("R2 both high late", V_HIGH);
    setup(1'b0, 1'b0, 2'b01);
    trip_i = 1'b1;
    wait_cnt(100); check_out("R2 both low with trip", V_LOWS);
    trip_i = 1'b0;
  endtask

  task automatic t_no_trip;
    setup(1'b1, 1'b0, 2'b00);
    wait_cnt(100); check_out("R3 forward drive mid", V_FWD);
    wait_cnt(195); check_out("R3 forward drive end", V_FWD);
  endtask

  task automatic t_blank_slow;
    setup(1'b1, 1'b0, 2'b00);
    trip_i = 1'b1;
    wait_cnt(35); check_out("R4 trip masked in blanking", V_FWD);
    wait_cnt(55); check_out("R5 slow decay", V_LOWS);
    wait_cnt(190); check_out("R5 slow held to end", V_LOWS);
    wait_cnt(30); check_out("R4 next period min on-time", V_FWD);
    trip_i = 1'b0;
  endtask

  task automatic t_reverse_slow;
    setup(1'b0, 1'b1, 2'b00);
    wait_cnt(30); check_out("R3 reverse drive", V_REV);
    pulse_trip(60);
    wait_cnt(80); check_out("R5 reverse slow decay", V_LOWS);
  endtask

  task automatic t_fast;
    setup(1'b1, 1'b0, 2'b10);
    pulse_trip(60);
    wait_cnt(80); check_out("R6 fast reverses bridge", V_REV);
    wait_cnt(100); zero_i = 1'b1;
    wait_cnt(102); zero_i = 1'b0;
    wait_cnt(110); check_out("R6 zero detect floats", V_OFF);
    wait_cnt(170); check_out("R6 floats to end", V_OFF);
    wait_cnt(20); check_out("R3 drive after fast period", V_FWD);
  endtask

  task automatic t_mixed;
    setup(1'b1, 1'b0, 2'b01);
    pulse_trip(60);
    wait_cnt(80);  check_out("R7 mixed fast part", V_REV);
    wait_cnt(145); check_out("R7 mixed before switch", V_REV);
    wait_cnt(165); check_out("R7 mixed slow part", V_LOWS);
    setup(1'b1, 1'b0, 2'b11);
    pulse_trip(60);
    wait_cnt(100); check_out("R7 spare code fast part", V_REV);
    wait_cnt(170); check_out("R7 spare code slow part", V_LOWS);
    setup(1'b1, 1'b0, 2'b01);
    wait_cnt(168); check_out("R7 drive before late trip", V_FWD);
    pulse_trip(170);
    wait_cnt(174); check_out("R7 late trip never reverses", 4'b0001);
    wait_cnt(190); check_out("R7 late trip goes slow", V_LOWS);
  endtask

  initial begin
    t_reset();
    t_equal_inputs();
    t_no_trip();
    t_blank_slow();
    t_reverse_slow();
    t_fast();
    t_mixed();
    repeat (5) @(negedge clk);
    checks++;
    if (shoot_viol != 0) begin
      errors++;
      $display("FAIL R8: shoot-through cycles actual %0d expected 0", shoot_viol);
    end
    checks++;
    if (gap_viol != 0 || turn_ons < 10) begin
      errors++;
      $display("FAIL R9: gap violations actual %0d expected 0 (turn-ons %0d)", gap_viol, turn_ons);
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule